// File: doc/BRIEF.md
# Suspend and Wakeup Power Controller

This block sequences the low-power state of a microcontroller-based USB peripheral. Firmware requests power-down by setting bit 0 of a power-control write. The controller then drops the oscillator enable, the PLL enable and the CPU clock enable. It waits in a suspended state until one of three wake sources fires: a dedicated wake pin whose polarity can be chosen, a second wake pin that may be handed over to general-purpose I/O, and a USB bus-activity indication.

On a wake event the oscillator is turned on for one cycle ahead of the PLL. The controller then waits for the PLL to report lock. A programmable timeout bounds that wait. Only after the wait ends are the CPU clock released and a one-cycle wakeup interrupt raised. A status register records which sources caused the last wake and whether the PLL wait timed out. Each status bit is cleared by writing 1 to it.

The controller runs on a free-running always-on clock, so wake detection keeps working while the main oscillator is stopped. Every wake input passes through a two-flop synchroniser on that clock.

Top module: `susp_wake_ctrl`

## Requirements
- R1: After reset, `osc_en`, `pll_en` and `cpu_clk_en` are 1, `wake_irq` is 0, `status` is 0, and the configuration is `5'b01110`: wake pin active low, all three sources enabled, second pin used as a wake pin.
- R2: A write with `pwr_we`=1 and `pwr_wdata[0]`=1 while running drives `osc_en`, `pll_en` and `cpu_clk_en` to 0 from the next cycle. They stay 0 until a wake event. A write with bit 0 clear has no effect.
- R3: Configuration bit 0 selects the wake-pin polarity: 0 means active low, 1 means active high. The pin is seen two clock edges after it changes.
- R4: The second wake pin is active high. It wakes the block only while configuration bit 4 (general-purpose I/O mode) is 0. While bit 4 is 1 it is ignored.
- R5: A high level on `bus_activity` wakes the block.
- R6: Configuration bits 1, 2 and 3 enable the wake pin, the second pin and bus activity respectively. A disabled source is ignored.
- R7: On a wake event there is one cycle with only `osc_en` high. `pll_en` then also goes high and stays high while waiting for `pll_lock`. In the cycle after lock is seen, `cpu_clk_en` and `wake_irq` go high, and `wake_irq` lasts exactly one cycle.
- R8: If `pll_lock` stays low, the PLL wait ends after max(1, limit) cycles, where the limit is written through `tmo_we`/`tmo_wdata`. The wake then proceeds, and `status[3]` is set and stays set until cleared.
- R9: A wake event present in the single cycle after the power-down write restarts the oscillator at once, so all clocks are off for exactly one cycle.
- R10: `status[0]`, `status[1]` and `status[2]` are set for the wake pin, the second pin and bus activity when that source causes a wake. Writing 1 to a bit through `sts_we` clears it, and a set in the same cycle wins over the clear.
- R11: While running, wake sources cause no interrupt and no status change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_we | input | 1 | Power-control write strobe |
| pwr_wdata | input | 8 | Power-control data, bit 0 requests power-down |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 5 | Polarity, source enables, GPIO mode |
| tmo_we | input | 1 | PLL timeout limit write strobe |
| tmo_wdata | input | TMO_W | PLL timeout limit in cycles |
| sts_we | input | 1 | Status write-one-to-clear strobe |
| sts_wdata | input | 4 | Status bits to clear |
| wake_pin | input | 1 | Asynchronous primary wake pin |
| wu2_pin | input | 1 | Asynchronous second wake pin |
| bus_activity | input | 1 | Asynchronous USB bus activity indication |
| pll_lock | input | 1 | PLL stable indication |
| osc_en | output | 1 | Oscillator enable |
| pll_en | output | 1 | PLL enable |
| cpu_clk_en | output | 1 | CPU clock release |
| wake_irq | output | 1 | One-cycle wakeup interrupt |
| status | output | 4 | Wake causes [2:0] and PLL timeout [3] |

## Verification
On every cycle the assertions check the ordering of the wake sequence: the PLL never starts before the oscillator, the CPU clock is never released without the interrupt, and the interrupt is always one cycle long and only follows a PLL-enabled cycle. They also check that a power-down request always stops the clocks and that the timeout flag stays set until cleared. Other behaviour is only visible in the bench scenarios, which compare against a cycle model: polarity selection, the GPIO override of the second pin, per-source enables, the wake that lands during entry, the timeout length and the write-one-to-clear rules.

// File: rtl/susp_wake_ctrl.sv
module susp_wake_ctrl #(
  parameter int TMO_W = 8,
  parameter int TMO_RST = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_we,
  input  logic [7:0]       pwr_wdata,
  input  logic             cfg_we,
  input  logic [4:0]       cfg_wdata,
  input  logic             tmo_we,
  input  logic [TMO_W-1:0] tmo_wdata,
  input  logic             sts_we,
  input  logic [3:0]       sts_wdata,
  input  logic             wake_pin,
  input  logic             wu2_pin,
  input  logic             bus_activity,
  input  logic             pll_lock,
  output logic             osc_en,
  output logic             pll_en,
  output logic             cpu_clk_en,
  output logic             wake_irq,
  output logic [3:0]       status
);

  localparam logic [4:0]       CFG_RST  = 5'b01110;
  localparam logic [2:0]       SYNC_RST = 3'b001;
  localparam logic [TMO_W-1:0] TMO_INIT = TMO_W'(TMO_RST);

  typedef enum logic [2:0] {
    ST_RUN, ST_ENTER, ST_SUSP, ST_OSC, ST_PLLW, ST_RES
  } st_t;

  st_t              st, st_nx;
  logic [2:0]       sync1, sync2;
  logic [4:0]       cfg;
  logic [TMO_W-1:0] tmo_lim, cnt;
  logic [3:0]       sts;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= SYNC_RST;
      sync2 <= SYNC_RST;
    end else begin
      sync1 <= {bus_activity, wu2_pin, wake_pin};
      sync2 <= sync1;
    end

  logic       pin_act;
  logic [2:0] hits;
  logic       waking, expire, timed_out;

  assign pin_act   = cfg[0] ? sync2[0] : ~sync2[0];
  assign hits      = {cfg[3] & sync2[2], cfg[2] & ~cfg[4] & sync2[1], cfg[1] & pin_act};
  assign waking    = (st == ST_ENTER || st == ST_SUSP) && (|hits);
  assign expire    = ({1'b0, cnt} + 1'b1) >= {1'b0, tmo_lim};
  assign timed_out = (st == ST_PLLW) && !pll_lock && expire;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_RUN:   if (pwr_we && pwr_wdata[0]) st_nx = ST_ENTER;
      ST_ENTER: st_nx = waking ? ST_OSC : ST_SUSP;
      ST_SUSP:  if (waking) st_nx = ST_OSC;
      ST_OSC:   st_nx = ST_PLLW;
      ST_PLLW:  if (pll_lock || expire) st_nx = ST_RES;
      ST_RES:   st_nx = ST_RUN;
      default:  st_nx = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= ST_RUN;
    else        st <= st_nx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cfg     <= CFG_RST;
      tmo_lim <= TMO_INIT;
    end else begin
      if (cfg_we) cfg     <= cfg_wdata;
      if (tmo_we) tmo_lim <= tmo_wdata;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              cnt <= '0;
    else if (st == ST_OSC)   cnt <= '0;
    else if (st == ST_PLLW)  cnt <= cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sts <= '0;
    else sts <= (sts & ~(sts_we ? sts_wdata : 4'b0))
              | {timed_out, waking ? hits : 3'b0};

  assign osc_en     = st inside {ST_RUN, ST_OSC, ST_PLLW, ST_RES};
  assign pll_en     = st inside {ST_RUN, ST_PLLW, ST_RES};
  assign cpu_clk_en = st inside {ST_RUN, ST_RES};
  assign wake_irq   = (st == ST_RES);
  assign status     = sts;

  assert_pd_stops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && !wake_irq && pwr_we && pwr_wdata[0]) |=> (!osc_en && !pll_en && !cpu_clk_en));

  assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |=> !wake_irq);

  assert_irq_after_pll_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |-> $past(pll_en));

  assert_pll_after_osc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_en) |-> $past(osc_en));

  assert_cpu_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_clk_en) |-> wake_irq);

  assert_timeout_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (status[3] && !(sts_we && sts_wdata[3])) |=> status[3]);

  assert_no_wake_in_run_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && !wake_irq) |=> !wake_irq);

endmodule

// File: tb/susp_wake_ctrl_tb.sv
module susp_wake_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TMO_W = 8;

  logic clk = 0, rst_n = 0;
  logic pwr_we = 0, cfg_we = 0, tmo_we = 0, sts_we = 0;
  logic [7:0] pwr_wdata = 0;
  logic [4:0] cfg_wdata = 0;
  logic [TMO_W-1:0] tmo_wdata = 0;
  logic [3:0] sts_wdata = 0;
  logic wake_pin = 1, wu2_pin = 0, bus_activity = 0, pll_lock = 0;
  logic osc_en, pll_en, cpu_clk_en, wake_irq;
  logic [3:0] status;

  int checks = 0, fails = 0;
  int n_off = 0, n_pw = 0, n_irq = 0;
  int lock_dly = 3, lk_cnt = 0;
  bit lock_kill = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  susp_wake_ctrl #(.TMO_W(TMO_W), .TMO_RST(64)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_we(pwr_we), .pwr_wdata(pwr_wdata),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .tmo_we(tmo_we), .tmo_wdata(tmo_wdata),
    .sts_we(sts_we), .sts_wdata(sts_wdata), .wake_pin(wake_pin), .wu2_pin(wu2_pin),
    .bus_activity(bus_activity), .pll_lock(pll_lock), .osc_en(osc_en), .pll_en(pll_en),
    .cpu_clk_en(cpu_clk_en), .wake_irq(wake_irq), .status(status));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model: phase 0 run, 1 entering, 2 asleep, 3 osc, 4 pll wait, 5 resume
  int m_ph, m_cnt, m_tmo;
  logic [2:0] m_q1, m_q2, m_hit;
  logic [4:0] m_cfg;
  logic [3:0] m_sts, nsts;
  assign m_hit[0] = m_cfg[1] && (m_cfg[0] ? m_q2[0] : !m_q2[0]);
  assign m_hit[1] = m_cfg[2] && !m_cfg[4] && m_q2[1];
  assign m_hit[2] = m_cfg[3] && m_q2[2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph <= 0; m_cnt <= 0; m_tmo <= 64; m_q1 <= 3'b001; m_q2 <= 3'b001;
      m_cfg <= 5'b01110; m_sts <= 0;
    end else begin
      m_q1 <= {bus_activity, wu2_pin, wake_pin};
      m_q2 <= m_q1;
      if (cfg_we) m_cfg <= cfg_wdata;
      if (tmo_we) m_tmo <= int'(tmo_wdata);
      nsts = m_sts;
      if (sts_we) nsts = nsts & ~sts_wdata;
      case (m_ph)
        0: if (pwr_we && pwr_wdata[0]) m_ph <= 1;
        1, 2: if (m_hit != 0) begin m_ph <= 3; nsts[2:0] = nsts[2:0] | m_hit; end
              else m_ph <= 2;
        3: begin m_ph <= 4; m_cnt <= 0; end
        4: if (pll_lock) m_ph <= 5;
           else if (m_cnt + 1 >= m_tmo) begin m_ph <= 5; nsts[3] = 1'b1; end
           else m_cnt <= m_cnt + 1;
        default: m_ph <= 0;
      endcase
      m_sts <= nsts;
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk(osc_en == (m_ph == 0 || m_ph >= 3), "R7 osc_en", osc_en, (m_ph == 0 || m_ph >= 3));
    chk(pll_en == (m_ph == 0 || m_ph >= 4), "R7 pll_en", pll_en, (m_ph == 0 || m_ph >= 4));
    chk(cpu_clk_en == (m_ph == 0 || m_ph == 5), "R7 cpu_clk_en", cpu_clk_en, (m_ph == 0 || m_ph == 5));
    chk(wake_irq == (m_ph == 5), "R7 wake_irq", wake_irq, (m_ph == 5));
    chk(status == m_sts, "R10 status", status, m_sts);
    if (!osc_en) n_off++;
    if (pll_en && !cpu_clk_en) n_pw++;
    if (wake_irq) n_irq++;
  end

  // PLL stand-in: locks lock_dly cycles after being enabled
  always begin
    @(posedge clk); #2;
    if (!pll_en || lock_kill) begin lk_cnt = 0; pll_lock = 0; end
    else if (lk_cnt >= lock_dly) pll_lock = 1;
    else lk_cnt++;
  end

  task automatic tick(); @(posedge clk); #2; endtask
  task automatic idle(input int n); repeat (n) tick(); endtask
  task automatic pwr_write(input logic [7:0] d);
    tick(); pwr_we = 1; pwr_wdata = d; tick(); pwr_we = 0;
  endtask
  task automatic cfg_write(input logic [4:0] d);
    tick(); cfg_we = 1; cfg_wdata = d; tick(); cfg_we = 0;
  endtask
  task automatic sts_clear(input logic [3:0] d);
    tick(); sts_we = 1; sts_wdata = d; tick(); sts_we = 0;
  endtask
  task automatic wait_irq(input int maxc, output bit got);
    got = 0;
    for (int i = 0; i < maxc && !got; i++) begin
      @(negedge clk);
      if (wake_irq) got = 1;
    end
    tick();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    bit got;
    idle(3); rst_n = 1;
    @(negedge clk);
    chk(osc_en && pll_en && cpu_clk_en, "R1 clocks on", {osc_en, pll_en, cpu_clk_en}, 7);
    chk(!wake_irq && status == 0, "R1 irq/status", {wake_irq, status}, 0);

    pwr_write(8'h00); @(negedge clk);
    chk(cpu_clk_en == 1, "R2 bit0 clear ignored", cpu_clk_en, 1);
    pwr_write(8'h01); @(negedge clk);
    chk(!cpu_clk_en && !osc_en && !pll_en, "R2 clocks stop", {osc_en, pll_en, cpu_clk_en}, 0);
    idle(10); @(negedge clk);
    chk(!osc_en, "R2 stays asleep", osc_en, 0);

    tick(); wake_pin = 0;
    wait_irq(50, got);
    chk(got, "R3 low pin wakes", got, 1);
    chk(status == 4'b0001, "R10 pin cause", status, 1);
    wake_pin = 1; idle(3);
    sts_clear(4'hF); @(negedge clk);
    chk(status == 0, "R10 w1c", status, 0);

    wake_pin = 0; cfg_write(5'b01111); idle(3);
    pwr_write(8'h01); idle(5); @(negedge clk);
    chk(!osc_en, "R3 low level ignored when active high", osc_en, 0);
    tick(); wake_pin = 1;
    wait_irq(50, got);
    chk(got && status == 4'b0001, "R3 high pin wakes", status, 1);
    cfg_write(5'b01110); sts_clear(4'hF); idle(3);

    cfg_write(5'b11110); pwr_write(8'h01); tick(); wu2_pin = 1;
    idle(20); @(negedge clk);
    chk(!osc_en, "R4 gpio mode ignored", osc_en, 0);
    cfg_write(5'b01110);
    wait_irq(50, got);
    chk(got && status == 4'b0010, "R4 second pin wakes", status, 2);
    wu2_pin = 0; sts_clear(4'hF); idle(3);

    cfg_write(5'b01100); pwr_write(8'h01); tick(); wake_pin = 0;
    idle(20); @(negedge clk);
    chk(!osc_en, "R6 disabled pin ignored", osc_en, 0);
    tick(); bus_activity = 1;
    wait_irq(50, got);
    chk(got && status == 4'b0100, "R5 bus wakes", status, 4);
    wake_pin = 1; bus_activity = 0; cfg_write(5'b01110); sts_clear(4'hF); idle(3);

    n_irq = 0; tick(); bus_activity = 1; wake_pin = 0; idle(10);
    bus_activity = 0; wake_pin = 1; idle(4); @(negedge clk);
    chk(n_irq == 0 && status == 0, "R11 run ignores wake", n_irq, 0);

    tick(); bus_activity = 1; idle(5); n_off = 0; n_irq = 0;
    pwr_write(8'h01);
    wait_irq(50, got);
    chk(got && n_off == 1, "R9 wake during entry", n_off, 1);
    chk(n_irq == 1, "R7 one irq cycle", n_irq, 1);
    bus_activity = 0; sts_clear(4'hF); idle(3);

    tick(); tmo_we = 1; tmo_wdata = 8'd5; tick(); tmo_we = 0;
    lock_kill = 1; n_pw = 0;
    pwr_write(8'h01); tick(); wake_pin = 0;
    wait_irq(100, got);
    chk(got && status[3], "R8 timeout resumes and flags", status, 9);
    chk(n_pw == 5, "R8 wait length", n_pw, 5);
    lock_kill = 0; wake_pin = 1; idle(5); @(negedge clk);
    chk(status[3], "R8 flag sticky", status, 9);
    sts_clear(4'b1000); @(negedge clk);
    chk(status == 4'b0001, "R10 selective clear", status, 1);

    idle(3);
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule